// File: doc/BRIEF.md
# Three-Level Page Table Walker

The block turns a 32-bit virtual address into a 36-bit physical address. It walks a table tree held in memory. A walk starts in a context table. The table's base comes from a 28-bit pointer field, and the current 16-bit context number picks one word in that table. From there the walk descends through up to three more tables, indexed by successive slices of the virtual address. Each step is a single 32-bit word read on a request/acknowledge memory port, and only one read is in flight at any time.

Every word read carries a two-bit type code in its lowest bits. A pointer word names the next table. A leaf word carries a physical page number plus attribute bits, and the attribute bits are returned untouched. A leaf may appear at the first or second level, where it maps a 16 MB or 256 KB region. The walk then ends early, and the untranslated low address bits pass straight through.

A walk that cannot finish reports a fault instead. The fault carries the level of the word that stopped it and a reason code. Whether the walk succeeds or faults, it ends with a one-cycle completion pulse, together with the entry word last read and the access-type bit the request carried.

Top module: `ptw_top`

## Requirements
- R1: After reset `req_ready` is 1, `mem_req` is 0 and `done` is 0.
- R2: The first read of a walk goes to byte address `{ctx_tbl_ptr, 8'h00} + 4*ctx_num`. The pointer field and the context number are taken in the cycle the request is accepted, and later changes to them have no effect on that walk.
- R3: Type code (entry bits 1:0): 0 = invalid, 1 = pointer, 2 = leaf, 3 = reserved. When a pointer word is read at level L (0, 1 or 2), the next read goes to `{entry[31:4], 8'h00} + 4*index`. The index is VA[31:24] at level 1, VA[23:18] at level 2 and VA[17:12] at level 3.
- R4: A leaf at level 3 completes with `done_fault`=0, `done_level`=3 and `done_paddr = {pte[31:8], VA[11:0]}`. `done_pte` is the leaf word.
- R5: A leaf at level 2 completes with `done_level`=2 and `done_paddr = {pte[31:14], VA[17:0]}`.
- R6: A leaf at level 1 completes with `done_level`=1 and `done_paddr = {pte[31:20], VA[23:0]}`.
- R7: An invalid word at any level completes with `done_fault`=1, `done_level` set to that level and `done_reason`=0. `done_pte` is the word read, and no further reads are made.
- R8: A reserved-type word at any level faults with `done_reason`=1 at that level.
- R9: A pointer word at level 3 faults with `done_reason`=2 and `done_level`=3.
- R10: A leaf word in the context table (level 0) faults with `done_reason`=3 and `done_level`=0.
- R11: `mem_req` stays high with `mem_addr` stable until `mem_ack`. Each accepted request gives exactly one single-cycle `done` pulse, and the result outputs hold between pulses. While a walk runs, `req_ready` is 0 and `req_valid` is ignored.
- R12: `done_write` returns the `req_write` value of the request that is completing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request; accepted when `req_ready` is 1 |
| req_ready | output | 1 | Walker idle, able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access type of the request (1 = write) |
| ctx_tbl_ptr | input | 28 | Context table base, byte address bits 35:8 |
| ctx_num | input | 16 | Current context number |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 36 | Byte address of the word to read |
| mem_ack | input | 1 | Read accepted; `mem_rdata` valid this cycle |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | Walk ended in a fault |
| done_reason | output | 2 | Fault reason code |
| done_level | output | 2 | Level (0 to 3) of the last word read |
| done_pte | output | 32 | Last word read (leaf or faulting word) |
| done_paddr | output | 36 | Translated physical address (0 on a fault) |
| done_write | output | 1 | Access type of the completed request |

## Verification
The bench uses the default widths: a 32-bit virtual address, a 16-bit context number, 28-bit table pointer fields and a 36-bit physical address. These sizes let it reach several corner cases: context 0 and context 0xFFFF, a context table placed at the very top of the 36-bit space, and leaf words at each of levels 1, 2 and 3 under a behavioural model. The memory acknowledge delay is varied from zero to three cycles. This exercises back-to-back acknowledges and long holds of one read, and a request raised during a long walk checks that the walker ignores it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W      = 32;
    localparam int ENT_W     = 32;
    localparam int CTX_W     = 16;
    localparam int PTR_SHIFT = 4;
    localparam int PTR_W     = ENT_W - PTR_SHIFT;
    localparam int PA_W      = ENT_W + PTR_SHIFT;
    localparam int BASE_PAD  = 2 * PTR_SHIFT;
    localparam int PPN_LSB   = 8;
    localparam int PPN_W     = ENT_W - PPN_LSB;
    localparam int ENT_LOG   = 2;
    localparam int L1_BITS   = 8;
    localparam int L2_BITS   = 6;
    localparam int L3_BITS   = 6;
    localparam int PAGE_BITS = VA_W - L1_BITS - L2_BITS - L3_BITS;
    localparam int L1_SHIFT  = VA_W - L1_BITS;
    localparam int L2_SHIFT  = L1_SHIFT - L2_BITS;
    localparam int L3_SHIFT  = PAGE_BITS;
    localparam int VHI_W     = VA_W - PAGE_BITS;
    localparam int LVL_W     = 2;
    localparam int LAST_LVL  = 3;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_PTR     = 2'd1,
        ET_LEAF    = 2'd2,
        ET_RSVD    = 2'd3
    } etype_e;

    typedef enum logic [1:0] {
        FR_INVALID  = 2'd0,
        FR_RSVD     = 2'd1,
        FR_PTR_LAST = 2'd2,
        FR_LEAF_CTX = 2'd3
    } freason_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } state_e;

    typedef struct packed {
        state_e            st;
        lvl_t              lvl;
        logic [VA_W-1:0]   va;
        logic              wr;
        logic [PA_W-1:0]   addr;
        logic              done;
        logic              fault;
        freason_e          reason;
        lvl_t              dlvl;
        logic [ENT_W-1:0]  pte;
        logic [PA_W-1:0]   pa;
        logic              dwr;
    } walk_regs_t;

endpackage

// File: rtl/ptw_decode.sv
module ptw_decode
    import ptw_pkg::*;
(
    input  logic [1:0] etype,
    input  lvl_t       level,
    output logic       descend,
    output logic       bad,
    output freason_e   reason
);

    always_comb begin
        descend = 1'b0;
        bad     = 1'b0;
        reason  = FR_INVALID;
        unique case (etype_e'(etype))
            ET_INVALID: begin
                bad    = 1'b1;
                reason = FR_INVALID;
            end
            ET_PTR: begin
                if (level == lvl_t'(LAST_LVL)) begin
                    bad    = 1'b1;
                    reason = FR_PTR_LAST;
                end else begin
                    descend = 1'b1;
                end
            end
            ET_LEAF: begin
                if (level == '0) begin
                    bad    = 1'b1;
                    reason = FR_LEAF_CTX;
                end
            end
            default: begin
                bad    = 1'b1;
                reason = FR_RSVD;
            end
        endcase
    end

endmodule

// File: rtl/ptw_addr.sv
module ptw_addr
    import ptw_pkg::*;
#(
    parameter int P_PTR_W = PTR_W,
    parameter int P_CTX_W = CTX_W,
    parameter int P_VHI_W = VHI_W,
    parameter int P_PA_W  = PA_W
) (
    input  logic [P_PTR_W-1:0] ptr_hi,
    input  lvl_t               tgt,
    input  logic [P_VHI_W-1:0] va_hi,
    input  logic [P_CTX_W-1:0] ctx,
    output logic [P_PA_W-1:0]  addr
);

    localparam int L2_TOP = P_VHI_W - L1_BITS - 1;

    logic [P_CTX_W-1:0] idx;
    logic [P_PA_W-1:0]  base;

    always_comb begin
        unique case (tgt)
            2'd0:    idx = ctx;
            2'd1:    idx = P_CTX_W'(va_hi[P_VHI_W-1 -: L1_BITS]);
            2'd2:    idx = P_CTX_W'(va_hi[L2_TOP -: L2_BITS]);
            default: idx = P_CTX_W'(va_hi[L3_BITS-1:0]);
        endcase
    end

    assign base = {ptr_hi, {BASE_PAD{1'b0}}};
    assign addr = base + P_PA_W'({idx, {ENT_LOG{1'b0}}});

endmodule

// File: rtl/ptw_pa.sv
module ptw_pa
    import ptw_pkg::*;
#(
    parameter int P_PPN_W = PPN_W,
    parameter int P_VLO_W = L1_SHIFT,
    parameter int P_PA_W  = PA_W
) (
    input  logic [P_PPN_W-1:0] ppn,
    input  logic [P_VLO_W-1:0] va_lo,
    input  lvl_t               level,
    output logic [P_PA_W-1:0]  pa
);

    logic [P_PA_W-1:0] cand [1:LAST_LVL];

    for (genvar g = 1; g <= LAST_LVL; g++) begin : g_leaf
        localparam int OFF = (g == 1) ? L1_SHIFT : ((g == 2) ? L2_SHIFT : L3_SHIFT);
        assign cand[g] = {ppn[P_PPN_W-1 : OFF-PAGE_BITS], va_lo[OFF-1:0]};
    end

    always_comb begin
        unique case (level)
            2'd1:    pa = cand[1];
            2'd2:    pa = cand[2];
            default: pa = cand[3];
        endcase
    end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    input  logic [PA_W-1:0]  addr_in,
    input  logic             descend,
    input  logic             bad,
    input  freason_e         reason,
    input  logic [PA_W-1:0]  pa_in,
    input  logic             mem_ack,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             walking,
    output lvl_t             lvl,
    output logic [VA_W-1:0]  va,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    output logic             done,
    output logic             done_fault,
    output logic [1:0]       done_reason,
    output lvl_t             done_level,
    output logic [ENT_W-1:0] done_pte,
    output logic [PA_W-1:0]  done_paddr,
    output logic             done_write
);

    walk_regs_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_WALK;
                    d.lvl  = '0;
                    d.va   = req_va;
                    d.wr   = req_write;
                    d.addr = addr_in;
                end
            end
            ST_WALK: begin
                if (mem_ack) begin
                    if (descend) begin
                        d.lvl  = q.lvl + 1'b1;
                        d.addr = addr_in;
                    end else begin
                        d.st     = ST_IDLE;
                        d.done   = 1'b1;
                        d.dlvl   = q.lvl;
                        d.pte    = mem_rdata;
                        d.dwr    = q.wr;
                        d.fault  = bad;
                        d.reason = bad ? reason : FR_INVALID;
                        d.pa     = bad ? '0 : pa_in;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign walking     = (q.st == ST_WALK);
    assign lvl         = q.lvl;
    assign va          = q.va;
    assign mem_req     = walking;
    assign mem_addr    = q.addr;
    assign done        = q.done;
    assign done_fault  = q.fault;
    assign done_reason = q.reason;
    assign done_level  = q.dlvl;
    assign done_pte    = q.pte;
    assign done_paddr  = q.pa;
    assign done_write  = q.dwr;

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic [PTR_W-1:0]  ctx_tbl_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_ack,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              done,
    output logic              done_fault,
    output logic [1:0]        done_reason,
    output logic [LVL_W-1:0]  done_level,
    output logic [ENT_W-1:0]  done_pte,
    output logic [PA_W-1:0]   done_paddr,
    output logic              done_write
);

    logic             walking;
    lvl_t             lvl_q;
    logic [VA_W-1:0]  va_q;
    logic [VA_W-1:0]  va_sel;
    logic [PTR_W-1:0] ptr_sel;
    lvl_t             tgt_lvl;
    logic [PA_W-1:0]  next_addr;
    logic [PA_W-1:0]  leaf_pa;
    logic             dec_descend;
    logic             dec_bad;
    freason_e         dec_reason;

    assign ptr_sel = walking ? mem_rdata[ENT_W-1:PTR_SHIFT] : ctx_tbl_ptr;
    assign tgt_lvl = walking ? lvl_t'(lvl_q + 1'b1) : '0;
    assign va_sel  = walking ? va_q : req_va;

    ptw_addr u_addr (
        .ptr_hi (ptr_sel),
        .tgt    (tgt_lvl),
        .va_hi  (va_sel[VA_W-1:PAGE_BITS]),
        .ctx    (ctx_num),
        .addr   (next_addr)
    );

    ptw_decode u_decode (
        .etype   (mem_rdata[1:0]),
        .level   (lvl_q),
        .descend (dec_descend),
        .bad     (dec_bad),
        .reason  (dec_reason)
    );

    ptw_pa u_pa (
        .ppn   (mem_rdata[ENT_W-1:PPN_LSB]),
        .va_lo (va_q[L1_SHIFT-1:0]),
        .level (lvl_q),
        .pa    (leaf_pa)
    );

    ptw_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_va      (req_va),
        .req_write   (req_write),
        .addr_in     (next_addr),
        .descend     (dec_descend),
        .bad         (dec_bad),
        .reason      (dec_reason),
        .pa_in       (leaf_pa),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .walking     (walking),
        .lvl         (lvl_q),
        .va          (va_q),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .done        (done),
        .done_fault  (done_fault),
        .done_reason (done_reason),
        .done_level  (done_level),
        .done_pte    (done_pte),
        .done_paddr  (done_paddr),
        .done_write  (done_write)
    );

    assign req_ready = !walking;

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
    import ptw_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic [PTR_W-1:0] ctx_tbl_ptr,
    input logic [CTX_W-1:0] ctx_num,
    input logic             mem_req,
    input logic [PA_W-1:0]  mem_addr,
    input logic             mem_ack,
    input logic             done,
    input logic             done_fault,
    input logic [1:0]       done_reason,
    input logic [LVL_W-1:0] done_level,
    input logic [ENT_W-1:0] done_pte,
    input logic [PA_W-1:0]  done_paddr
);

    logic [PA_W-1:0] first_addr;
    assign first_addr = {ctx_tbl_ptr, 8'h00} + (PA_W'(ctx_num) << 2);

    // R2: the walk's first read uses the pointer and context seen at acceptance
    assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> mem_addr == $past(first_addr));

    // R11: a read is held with a stable address until acknowledged
    assert_hold_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R11: no read while the walker reports itself idle
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    // R11: completion is a single-cycle pulse
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: results hold between completions
    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(done_pte) && $stable(done_paddr) && $stable(done_level));

    // R4: a level-3 leaf places its page number at the top of the address
    assert_leaf3_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_fault && done_level == 2'd3 |-> done_paddr[PA_W-1:PAGE_BITS] == done_pte[ENT_W-1:PPN_LSB]);

    // R5: a successful walk always ended on a leaf word below the context level
    assert_leaf_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done && !done_fault |-> done_pte[1:0] == 2'd2 && done_level != 2'd0);

    // R8: a reserved-type fault carries a type-3 word
    assert_rsvd_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault && done_reason == 2'd1 |-> done_pte[1:0] == 2'd3);

    // R9: a pointer-at-last-level fault is reported at level 3
    assert_ptr_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault && done_reason == 2'd2 |-> done_level == 2'd3);

    // R10: a leaf in the context table is reported at level 0
    assert_leaf_ctx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault && done_reason == 2'd3 |-> done_level == 2'd0);

endmodule

bind ptw_top ptw_checker u_ptw_checker (.*);

// File: tb/ptw_top_bench.sv
module ptw_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0;
    logic [27:0] ctx_tbl_ptr = '0;
    logic [15:0] ctx_num = '0;
    logic        mem_req;
    logic [35:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done;
    logic        done_fault;
    logic [1:0]  done_reason;
    logic [1:0]  done_level;
    logic [31:0] done_pte;
    logic [35:0] done_paddr;
    logic        done_write;

    always #10 clk = ~clk;

    ptw_top u_ptw_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
        .ctx_tbl_ptr(ctx_tbl_ptr), .ctx_num(ctx_num),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .done_fault(done_fault), .done_reason(done_reason), .done_level(done_level),
        .done_pte(done_pte), .done_paddr(done_paddr), .done_write(done_write)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] mem [logic [35:0]];
    logic [35:0] exp_q [$];
    bit          exp_pend = 0;
    bit          e_fault;
    int          e_reason;
    int          e_level;
    logic [31:0] e_pte;
    logic [35:0] e_pa;
    bit          e_wr;
    int          rd_idx = 0;
    int          dly = 0;
    int          wcnt = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [35:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] ptd(input logic [35:0] phys);
        return {phys[35:8], 4'h1};
    endfunction

    function automatic int idx_of(input logic [31:0] va, input int lv);
        if (lv == 1) return int'(va >> 24) & 255;
        if (lv == 2) return int'(va >> 18) & 63;
        return int'(va >> 12) & 63;
    endfunction

    task automatic model(input logic [31:0] va, input logic [27:0] cp, input logic [15:0] cx, input bit wr);
        logic [35:0] a;
        logic [31:0] e;
        logic [35:0] full;
        logic [35:0] span;
        int lv;
        bit go;
        exp_q.delete();
        a  = {cp, 8'h00} + 36'(cx) * 4;
        lv = 0;
        go = 1;
        while (go) begin
            exp_q.push_back(a);
            e = rd(a);
            if (e[1:0] == 2'd1 && lv < 3) begin
                lv = lv + 1;
                a  = {e[31:4], 8'h00} + 36'(idx_of(va, lv)) * 4;
            end else begin
                go = 0;
            end
        end
        e_pte = e; e_level = lv; e_wr = wr; e_pa = '0; e_fault = 1; e_reason = 0;
        case (e[1:0])
            2'd0: e_reason = 0;
            2'd3: e_reason = 1;
            2'd1: e_reason = 2;
            default: begin
                if (lv == 0) e_reason = 3;
                else begin
                    e_fault = 0;
                    span = 36'd1 << ((lv == 1) ? 24 : ((lv == 2) ? 18 : 12));
                    full = {e[31:8], 12'h000};
                    e_pa = full - (full % span) + (36'(va) % span);
                end
            end
        endcase
        rd_idx   = 0;
        exp_pend = 1;
    endtask

    // reference comparison and memory responder, away from the active edge
    always @(negedge clk) begin
        string t;
        if (rst_n) begin
            if (done) begin
                if (!exp_pend) begin
                    n_chk++; n_fail++;
                    $display("FAIL R11 unexpected completion actual=1 expected=0");
                end else begin
                    chk("R11 reads left at completion", 64'(exp_q.size()), 64'd0);
                    chk("R12 access type echo", 64'(done_write), 64'(e_wr));
                    if (e_fault) begin
                        case (e_reason)
                            0: t = "R7";
                            1: t = "R8";
                            2: t = "R9";
                            default: t = "R10";
                        endcase
                        chk({t, " fault flag"}, 64'(done_fault), 64'd1);
                        chk({t, " fault level"}, 64'(done_level), 64'(e_level));
                        chk({t, " fault reason"}, 64'(done_reason), 64'(e_reason));
                        chk({t, " fault word"}, 64'(done_pte), 64'(e_pte));
                        chk({t, " fault paddr"}, 64'(done_paddr), 64'd0);
                    end else begin
                        t = (e_level == 3) ? "R4" : ((e_level == 2) ? "R5" : "R6");
                        chk({t, " fault flag"}, 64'(done_fault), 64'd0);
                        chk({t, " level"}, 64'(done_level), 64'(e_level));
                        chk({t, " pte"}, 64'(done_pte), 64'(e_pte));
                        chk({t, " paddr"}, 64'(done_paddr), 64'(e_pa));
                    end
                    exp_pend = 0;
                end
            end
            mem_ack = 1'b0;
            if (mem_req) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R11 read with none expected actual=%h expected=none", mem_addr);
                end else if (wcnt >= dly) begin
                    t = (rd_idx == 0) ? "R2 context read address" : "R3 table read address";
                    chk(t, 64'(mem_addr), 64'(exp_q[0]));
                    mem_rdata = rd(mem_addr);
                    mem_ack   = 1'b1;
                    void'(exp_q.pop_front());
                    rd_idx++;
                    wcnt = 0;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic [27:0] cp, input logic [15:0] cx,
                        input bit wr, input int d, input bit poke);
        int t;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        dly  = d;
        wcnt = 0;
        model(va, cp, cx, wr);
        req_va = va; ctx_tbl_ptr = cp; ctx_num = cx; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid   = 1'b0;
        ctx_num     = ~cx;
        ctx_tbl_ptr = ~cp;
        if (poke) begin
            @(negedge clk);
            req_valid = 1'b1; req_va = ~va; req_write = ~wr;
            @(negedge clk);
            req_valid = 1'b0;
        end
        t = 0;
        while (exp_pend && t < 400) begin
            @(negedge clk);
            t++;
        end
        if (exp_pend) begin
            n_chk++; n_fail++;
            $display("FAIL R11 walk did not complete actual=pending expected=done");
            exp_pend = 0;
        end
        repeat (3) @(negedge clk);
    endtask

    localparam logic [27:0] CP1 = 28'h0001000;
    localparam logic [27:0] CP2 = 28'h0080000;
    localparam logic [27:0] CP3 = 28'hF000000;
    localparam logic [35:0] CT1 = 36'h0_0010_0000;
    localparam logic [35:0] CT2 = 36'h0_0800_0000;
    localparam logic [35:0] CT3 = 36'hF_0000_0000;
    localparam logic [35:0] L1A = 36'h0_0020_0000;
    localparam logic [35:0] L2A = 36'h0_0030_0000;
    localparam logic [35:0] L3A = 36'h0_0040_0000;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] va1, va2, va3, va4, va5, va7, va8;
        va1 = 32'h1234_5678;
        va2 = 32'h1298_7654;
        va3 = 32'h7700_1234;
        va4 = 32'h1235_0000;
        va5 = 32'hEE00_0000;
        va7 = 32'h12C0_0000;
        va8 = 32'h1234_A000;

        mem[CT1 + 36'd20] = ptd(L1A);
        mem[CT1 + 36'd28] = 32'h0000_0102;
        mem[CT2 + 36'h3FFFC] = ptd(L1A);
        mem[CT2] = ptd(L1A);
        mem[CT3 + 36'd4] = ptd(L1A);
        mem[L1A + 36'(idx_of(va1, 1)) * 4] = ptd(L2A);
        mem[L1A + 36'(idx_of(va3, 1)) * 4] = 32'hC0FF_EE22;
        mem[L2A + 36'(idx_of(va1, 2)) * 4] = ptd(L3A);
        mem[L2A + 36'(idx_of(va2, 2)) * 4] = 32'h5566_778A;
        mem[L2A + 36'(idx_of(va7, 2)) * 4] = 32'h0000_1233;
        mem[L3A + 36'(idx_of(va1, 3)) * 4] = 32'hABCD_EFAE;
        mem[L3A + 36'(idx_of(va8, 3)) * 4] = ptd(36'h0_0050_0000);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset req_ready", 64'(req_ready), 64'd1);
        chk("R1 reset mem_req", 64'(mem_req), 64'd0);
        chk("R1 reset done", 64'(done), 64'd0);

        walk(va1, CP1, 16'd5, 1'b0, 0, 1'b0);   // R4 full walk, immediate acknowledges
        walk(va1, CP1, 16'd5, 1'b1, 2, 1'b0);   // R4 with slow memory, R12
        walk(va2, CP1, 16'd5, 1'b1, 1, 1'b0);   // R5 level-2 leaf
        walk(va3, CP1, 16'd5, 1'b0, 0, 1'b0);   // R6 level-1 leaf
        walk(va4, CP1, 16'd5, 1'b0, 1, 1'b0);   // R7 invalid at level 3
        walk(va5, CP1, 16'd5, 1'b1, 0, 1'b0);   // R7 invalid at level 1
        walk(va1, CP1, 16'd9, 1'b0, 2, 1'b0);   // R7 invalid at level 0
        walk(va7, CP1, 16'd5, 1'b0, 0, 1'b0);   // R8 reserved at level 2
        walk(va8, CP1, 16'd5, 1'b1, 0, 1'b0);   // R9 pointer at level 3
        walk(va1, CP1, 16'd7, 1'b0, 1, 1'b0);   // R10 leaf in context table
        walk(va1, CP1, 16'd5, 1'b1, 3, 1'b1);   // R11 request during a walk is ignored
        walk(va1, CP2, 16'hFFFF, 1'b0, 0, 1'b0); // R2 highest context number
        walk(va3, CP2, 16'h0000, 1'b1, 1, 1'b0); // R2 context zero
        walk(va2, CP3, 16'h0001, 1'b0, 0, 1'b0); // R2 table at the top of the space

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule